// File: doc/BRIEF.md
# Peripheral DMA Channel with Automatic Buffer Reload

This block is one DMA channel. It moves data items between a peripheral's holding register and memory. The peripheral asks for each item by raising a request line. The channel performs one single-beat memory access for that item and then pulses an acknowledge back to the peripheral. Software programs the channel through a small word-indexed register port. It sets the item size, the direction, a current memory address, a remaining-item count and a second reload address and count pair.

When the remaining count runs out and the reload count is non-zero, the channel switches to the second buffer without any software step. It does this by copying the reload pair into the current pair and then clearing the reload count. This raises the reload-empty interrupt source, which tells software it may queue the next buffer. The channel reports three interrupt sources, each gated by a mask that software sets and clears through separate registers:

- reload-empty
- fully finished
- memory error

A memory error freezes the channel until software turns it off and on again.

Top module: `pdma_chan`

Register map (word index on `reg_addr`):

| Index | Access | Content |
|-------|--------|---------|
| 0 | write | control |
| 1 | read | status |
| 2 | read/write | mode |
| 3 | read/write | current address |
| 4 | read/write | remaining count |
| 5 | read/write | reload address |
| 6 | read/write | reload count |
| 7 | write | mask set |
| 8 | write | mask clear |
| 9 | read | mask |
| 10 | read | raw interrupt status |

In the control register, bit 0 turns the channel on and bit 1 turns it off. Bit 1 wins when both are written. Interrupt source bit positions are: bit 0 reload-empty, bit 1 finished, bit 2 error.

## Requirements
- R1: After reset the channel is off, the address, count, reload pair and mask are zero, raw interrupt status reads 3'b011, and `irq` is low.
- R2: Mode bits [1:0] select the item size: 0 byte, 1 half-word, 2 word (3 acts as word). `mem_size` carries this value. After each successful item the current address advances by 1, 2 or 4 respectively.
- R3: The remaining count is 16 bits and drops by exactly one per successful item, whatever the size.
- R4: The current address and remaining count can be read through registers 3 and 4 between items while the channel is on.
- R5: When an item completes with a count of 1 and a non-zero reload count, the current address and count take the reload values in the same cycle, and the reload count becomes zero.
- R6: Writing control bit 0 turns the channel on, writing bit 1 turns it off, and status bit 0 reads the on state. No memory access starts while the channel is off.
- R7: Writing ones to register 7 sets mask bits and writing ones to register 8 clears them. Register 9 reads the mask. `irq` is high exactly when some source bit and its mask bit are both set.
- R8: Source bit 0 is set while the reload count is zero. Source bit 1 is set while both counts are zero. Source bit 2 is set after a memory error.
- R9: Mode bit 2 selects direction. When it is 0, `per_rdata` is written to memory (`mem_we`=1). When it is 1, memory is read and the data is returned on `per_wdata` with the acknowledge.
- R10: An errored access updates neither address nor count and gives no acknowledge. Error status holds and no further access starts until control bit 0 is written again, which clears it.
- R11: One item moves per peripheral request. `per_ack` pulses for one cycle only after a successful response. No request is acknowledged while the count is zero.
- R12: `mem_req` stays high with a steady `mem_addr` until `mem_rsp` arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 4 | register word index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for `reg_addr` (combinational) |
| per_req | input | 1 | peripheral item request |
| per_rdata | input | 32 | peripheral holding-register data (towards memory) |
| per_ack | output | 1 | one-cycle item acknowledge |
| per_wdata | output | 32 | data for the peripheral, valid with `per_ack` |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | memory access is a write |
| mem_addr | output | 32 | memory byte address |
| mem_size | output | 2 | item size code |
| mem_wdata | output | 32 | memory write data |
| mem_rsp | input | 1 | memory response, one cycle |
| mem_err | input | 1 | response carries an error |
| mem_rdata | input | 32 | memory read data, valid with `mem_rsp` |
| irq | output | 1 | masked interrupt |

## Verification
The properties assume the following about the environment:

- `mem_rsp` arrives only while `mem_req` is high.
- The peripheral lowers `per_req` in the cycle after it sees `per_ack`.
- Software does not rewrite the address or count registers while an access is outstanding. The address-step, count and reload properties exclude cycles with a register write.

The bench keeps within these assumptions. Its memory model answers exactly one cycle after a request. Its peripheral task drops the request on the falling edge inside the acknowledge cycle. Register writes are issued only between items.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int unsigned REG_AW = 4;
    localparam int unsigned NSRC   = 3;

    localparam logic [REG_AW-1:0] RG_CTRL   = 4'd0;
    localparam logic [REG_AW-1:0] RG_STAT   = 4'd1;
    localparam logic [REG_AW-1:0] RG_MODE   = 4'd2;
    localparam logic [REG_AW-1:0] RG_ADDR   = 4'd3;
    localparam logic [REG_AW-1:0] RG_COUNT  = 4'd4;
    localparam logic [REG_AW-1:0] RG_RADDR  = 4'd5;
    localparam logic [REG_AW-1:0] RG_RCOUNT = 4'd6;
    localparam logic [REG_AW-1:0] RG_MSET   = 4'd7;
    localparam logic [REG_AW-1:0] RG_MCLR   = 4'd8;
    localparam logic [REG_AW-1:0] RG_MASK   = 4'd9;
    localparam logic [REG_AW-1:0] RG_ISTAT  = 4'd10;

    localparam int unsigned SRC_RLD = 0;
    localparam int unsigned SRC_FIN = 1;
    localparam int unsigned SRC_ERR = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } item_size_e;

    typedef struct packed {
        logic       to_per;
        item_size_e size;
    } chan_mode_t;

    typedef enum logic {
        ENG_IDLE,
        ENG_BUSY
    } eng_state_e;

    typedef struct packed {
        logic addr;
        logic count;
        logic raddr;
        logic rcount;
    } sw_wr_t;

    function automatic logic [2:0] size_step(item_size_e sz);
        case (sz)
            SZ_BYTE: size_step = 3'd1;
            SZ_HALF: size_step = 3'd2;
            default: size_step = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16,
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [AW-1:0]     cur_addr,
    input  logic [CW-1:0]     cur_count,
    input  logic [AW-1:0]     rld_addr,
    input  logic [CW-1:0]     rld_count,
    input  logic [NSRC-1:0]   src_stat,
    output logic              enabled,
    output logic              err_clr,
    output chan_mode_t        mode,
    output logic [NSRC-1:0]   imask,
    output sw_wr_t            sw_wr
);

    logic wr_ctrl;

    assign wr_ctrl      = reg_we && (reg_addr == RG_CTRL);
    assign err_clr      = wr_ctrl && reg_wdata[0] && !reg_wdata[1];
    assign sw_wr.addr   = reg_we && (reg_addr == RG_ADDR);
    assign sw_wr.count  = reg_we && (reg_addr == RG_COUNT);
    assign sw_wr.raddr  = reg_we && (reg_addr == RG_RADDR);
    assign sw_wr.rcount = reg_we && (reg_addr == RG_RCOUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled <= 1'b0;
            mode    <= '0;
            imask   <= '0;
        end else begin
            if (wr_ctrl) begin
                if (reg_wdata[1])      enabled <= 1'b0;
                else if (reg_wdata[0]) enabled <= 1'b1;
            end
            if (reg_we && reg_addr == RG_MODE)
                mode <= chan_mode_t'(reg_wdata[2:0]);
            if (reg_we && reg_addr == RG_MSET)
                imask <= imask | reg_wdata[NSRC-1:0];
            if (reg_we && reg_addr == RG_MCLR)
                imask <= imask & ~reg_wdata[NSRC-1:0];
        end
    end

    always_comb begin
        case (reg_addr)
            RG_STAT:   reg_rdata = DW'(enabled);
            RG_MODE:   reg_rdata = DW'(mode);
            RG_ADDR:   reg_rdata = DW'(cur_addr);
            RG_COUNT:  reg_rdata = DW'(cur_count);
            RG_RADDR:  reg_rdata = DW'(rld_addr);
            RG_RCOUNT: reg_rdata = DW'(rld_count);
            RG_MASK:   reg_rdata = DW'(imask);
            RG_ISTAT:  reg_rdata = DW'(src_stat);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enabled,
    input  logic          err_clr,
    input  chan_mode_t    mode,
    input  sw_wr_t        sw_wr,
    input  logic [DW-1:0] sw_wdata,
    input  logic          per_req,
    input  logic [DW-1:0] per_rdata,
    output logic          per_ack,
    output logic [DW-1:0] per_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rsp,
    input  logic          mem_err,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] cur_count,
    output logic [AW-1:0] rld_addr,
    output logic [CW-1:0] rld_count,
    output logic          err_flag
);

    eng_state_e    state;
    logic [DW-1:0] data_q;
    logic          can_start;
    logic          last_item;

    assign can_start = enabled && !err_flag && !per_ack && per_req && (cur_count != '0);
    assign last_item = (cur_count == CW'(1)) && (rld_count != '0);

    assign mem_req   = (state == ENG_BUSY);
    assign mem_we    = !mode.to_per;
    assign mem_addr  = cur_addr;
    assign mem_size  = mode.size;
    assign mem_wdata = data_q;
    assign per_wdata = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            data_q    <= '0;
            per_ack   <= 1'b0;
            cur_addr  <= '0;
            cur_count <= '0;
            rld_addr  <= '0;
            rld_count <= '0;
            err_flag  <= 1'b0;
        end else begin
            per_ack <= 1'b0;
            if (err_clr)      err_flag  <= 1'b0;
            if (sw_wr.addr)   cur_addr  <= AW'(sw_wdata);
            if (sw_wr.count)  cur_count <= CW'(sw_wdata);
            if (sw_wr.raddr)  rld_addr  <= AW'(sw_wdata);
            if (sw_wr.rcount) rld_count <= CW'(sw_wdata);
            case (state)
                ENG_IDLE: begin
                    if (can_start) begin
                        state <= ENG_BUSY;
                        if (!mode.to_per) data_q <= per_rdata;
                    end
                end
                default: begin
                    if (mem_rsp) begin
                        state <= ENG_IDLE;
                        if (mem_err) begin
                            err_flag <= 1'b1;
                        end else begin
                            per_ack <= 1'b1;
                            if (mode.to_per) data_q <= mem_rdata;
                            if (last_item) begin
                                cur_addr  <= rld_addr;
                                cur_count <= rld_count;
                                rld_count <= '0;
                            end else begin
                                cur_addr  <= cur_addr + AW'(size_step(mode.size));
                                cur_count <= cur_count - CW'(1);
                            end
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pdma_irq.sv
module pdma_irq
    import pdma_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic [CW-1:0]   cur_count,
    input  logic [CW-1:0]   rld_count,
    input  logic            err_flag,
    input  logic [NSRC-1:0] imask,
    output logic [NSRC-1:0] src_stat,
    output logic            irq
);

    always_comb begin
        src_stat          = '0;
        src_stat[SRC_RLD] = (rld_count == '0);
        src_stat[SRC_FIN] = (rld_count == '0) && (cur_count == '0);
        src_stat[SRC_ERR] = err_flag;
        irq               = |(src_stat & imask);
    end

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16,
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              per_req,
    input  logic [DW-1:0]     per_rdata,
    output logic              per_ack,
    output logic [DW-1:0]     per_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        mem_size,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_rsp,
    input  logic              mem_err,
    input  logic [DW-1:0]     mem_rdata,
    output logic              irq
);

    logic            enabled;
    logic            err_clr;
    logic            err_flag;
    chan_mode_t      mode;
    sw_wr_t          sw_wr;
    logic [NSRC-1:0] imask;
    logic [NSRC-1:0] src_stat;
    logic [AW-1:0]   cur_addr;
    logic [CW-1:0]   cur_count;
    logic [AW-1:0]   rld_addr;
    logic [CW-1:0]   rld_count;

    pdma_regs #(.AW(AW), .CW(CW), .DW(DW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cur_addr  (cur_addr),
        .cur_count (cur_count),
        .rld_addr  (rld_addr),
        .rld_count (rld_count),
        .src_stat  (src_stat),
        .enabled   (enabled),
        .err_clr   (err_clr),
        .mode      (mode),
        .imask     (imask),
        .sw_wr     (sw_wr)
    );

    pdma_engine #(.AW(AW), .CW(CW), .DW(DW)) eng_i (
        .clk       (clk),
        .rst       (rst),
        .enabled   (enabled),
        .err_clr   (err_clr),
        .mode      (mode),
        .sw_wr     (sw_wr),
        .sw_wdata  (reg_wdata),
        .per_req   (per_req),
        .per_rdata (per_rdata),
        .per_ack   (per_ack),
        .per_wdata (per_wdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_rsp   (mem_rsp),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .cur_addr  (cur_addr),
        .cur_count (cur_count),
        .rld_addr  (rld_addr),
        .rld_count (rld_count),
        .err_flag  (err_flag)
    );

    pdma_irq #(.CW(CW)) irq_i (
        .cur_count (cur_count),
        .rld_count (rld_count),
        .err_flag  (err_flag),
        .imask     (imask),
        .src_stat  (src_stat),
        .irq       (irq)
    );

endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic          enabled,
    input logic          err_clr,
    input logic          err_flag,
    input logic          mem_req,
    input logic          mem_rsp,
    input logic          mem_err,
    input logic [AW-1:0] mem_addr,
    input logic          per_ack,
    input logic [CW-1:0] cur_count,
    input logic [AW-1:0] rld_addr,
    input logic [CW-1:0] rld_count
);

    logic good_rsp;
    assign good_rsp = mem_req && mem_rsp && !mem_err && !reg_we;

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rsp && !reg_we) |=> (mem_req && $stable(mem_addr)));

    // R11
    ack_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        per_ack |-> $past(mem_rsp && !mem_err));

    // R11
    no_start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> ($past(cur_count) != '0));

    // R6
    no_start_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(enabled));

    // R3
    count_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (good_rsp && cur_count > CW'(1)) |=> (cur_count == $past(cur_count) - CW'(1)));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (good_rsp && cur_count == CW'(1) && rld_count != '0) |=>
        (mem_addr == $past(rld_addr) && cur_count == $past(rld_count) && rld_count == '0));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag);

endmodule

bind pdma_chan pdma_chan_chk #(.AW(AW), .CW(CW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .enabled   (enabled),
    .err_clr   (err_clr),
    .err_flag  (err_flag),
    .mem_req   (mem_req),
    .mem_rsp   (mem_rsp),
    .mem_err   (mem_err),
    .mem_addr  (mem_addr),
    .per_ack   (per_ack),
    .cur_count (cur_count),
    .rld_addr  (rld_addr),
    .rld_count (rld_count)
);

// File: tb/pdma_chan_tb_top.sv
module pdma_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic [31:0] per_rdata = '0;
    logic        per_ack;
    logic [31:0] per_wdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic        mem_rsp = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic        log_we   [64];
    logic [1:0]  log_size [64];
    int          nlog = 0;

    always #4 clk = ~clk;

    pdma_chan dut_i (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .per_req(per_req), .per_rdata(per_rdata), .per_ack(per_ack), .per_wdata(per_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rsp(mem_rsp), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .irq(irq)
    );

    // memory model: answers one cycle after a request, logs completed accesses
    always @(posedge clk) begin
        if (mem_req && !mem_rsp) begin
            mem_rsp   <= 1'b1;
            mem_err   <= (mem_addr == err_addr);
            mem_rdata <= {16'hA5A5, mem_addr[15:0]};
        end else begin
            mem_rsp <= 1'b0;
            mem_err <= 1'b0;
        end
        if (mem_req && mem_rsp && !mem_err) begin
            log_addr[nlog[5:0]] <= mem_addr;
            log_data[nlog[5:0]] <= mem_wdata;
            log_we[nlog[5:0]]   <= mem_we;
            log_size[nlog[5:0]] <= mem_size;
            nlog <= nlog + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // one peripheral request; returns whether it was acknowledged
    task automatic item(input logic [31:0] pdata, output bit acked, output logic [31:0] got);
        acked = 1'b0;
        got = '0;
        @(negedge clk);
        per_rdata = pdata;
        per_req = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (per_ack) begin
                acked = 1'b1;
                got = per_wdata;
                break;
            end
        end
        per_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] a, input logic [31:0] c, input logic [31:0] m);
        wr(4'd2, m);
        wr(4'd3, a);
        wr(4'd4, c);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd1, v);  chk("R1 status", v, 32'h0);
        rd(4'd3, v);  chk("R1 addr", v, 32'h0);
        rd(4'd4, v);  chk("R1 count", v, 32'h0);
        rd(4'd6, v);  chk("R1 rcount", v, 32'h0);
        rd(4'd9, v);  chk("R1 mask", v, 32'h0);
        rd(4'd10, v); chk("R1 istat", v, 32'h3);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_word_write;
        logic [31:0] v, g;
        bit a;
        int base;
        base = nlog;
        setup(32'h100, 32'd3, 32'h2);
        wr(4'd0, 32'h1);
        rd(4'd1, v); chk("R6 status on", v, 32'h1);
        rd(4'd10, v); chk("R8 busy istat", v, 32'h1);
        for (int k = 0; k < 3; k++) begin
            item(32'hC0DE_0000 + k, a, g);
            chk("R11 word ack", {31'b0, a}, 32'h1);
            if (k == 0) begin
                rd(4'd3, v); chk("R4 mid addr", v, 32'h104);
                rd(4'd4, v); chk("R4 mid count", v, 32'd2);
            end
        end
        chk("R11 one access per item", nlog - base, 32'd3);
        for (int k = 0; k < 3; k++) begin
            chk("R2 word addr", log_addr[base + k], 32'h100 + 4 * k);
            chk("R9 write data", log_data[base + k], 32'hC0DE_0000 + k);
            chk("R9 we", {31'b0, log_we[base + k]}, 32'h1);
            chk("R2 size code", {30'b0, log_size[base + k]}, 32'd2);
        end
        rd(4'd3, v); chk("R2 end addr", v, 32'h10C);
        rd(4'd4, v); chk("R3 end count", v, 32'd0);
        rd(4'd10, v); chk("R8 finished", v, 32'h3);
    endtask

    task automatic t_half_read;
        logic [31:0] v, g;
        bit a;
        int base;
        base = nlog;
        setup(32'h200, 32'd2, 32'h5);
        for (int k = 0; k < 2; k++) begin
            item(32'h0, a, g);
            chk("R11 half ack", {31'b0, a}, 32'h1);
            chk("R9 per_wdata", g, {16'hA5A5, 16'h200 + 16'(2 * k)});
            chk("R2 half addr", log_addr[base + k], 32'h200 + 2 * k);
            chk("R9 read we", {31'b0, log_we[base + k]}, 32'h0);
        end
        rd(4'd3, v); chk("R2 half end", v, 32'h204);
    endtask

    task automatic t_byte;
        logic [31:0] v, g;
        bit a;
        int base;
        base = nlog;
        setup(32'h301, 32'd2, 32'h0);
        item(32'h11, a, g);
        item(32'h22, a, g);
        chk("R2 byte addr0", log_addr[base], 32'h301);
        chk("R2 byte addr1", log_addr[base + 1], 32'h302);
        rd(4'd3, v); chk("R2 byte end", v, 32'h303);
        rd(4'd4, v); chk("R3 byte count", v, 32'd0);
    endtask

    task automatic t_reload;
        logic [31:0] v, g;
        bit a;
        int base;
        base = nlog;
        setup(32'h400, 32'd2, 32'h2);
        wr(4'd5, 32'h800);
        wr(4'd6, 32'd2);
        rd(4'd10, v); chk("R8 reload pending", v, 32'h0);
        item(32'h1, a, g);
        item(32'h2, a, g);
        rd(4'd3, v); chk("R5 swapped addr", v, 32'h800);
        rd(4'd4, v); chk("R5 swapped count", v, 32'd2);
        rd(4'd6, v); chk("R5 rcount cleared", v, 32'd0);
        rd(4'd10, v); chk("R8 reload empty", v, 32'h1);
        item(32'h3, a, g);
        item(32'h4, a, g);
        chk("R5 addr seq1", log_addr[base + 1], 32'h404);
        chk("R5 addr seq2", log_addr[base + 2], 32'h800);
        chk("R5 addr seq3", log_addr[base + 3], 32'h804);
        rd(4'd10, v); chk("R8 all done", v, 32'h3);
    endtask

    task automatic t_zero_count;
        logic [31:0] g;
        bit a;
        int base;
        base = nlog;
        item(32'h5, a, g);
        chk("R11 no ack at zero", {31'b0, a}, 32'h0);
        chk("R11 no access at zero", nlog - base, 32'd0);
    endtask

    task automatic t_disable;
        logic [31:0] v, g;
        bit a;
        int base;
        wr(4'd0, 32'h2);
        rd(4'd1, v); chk("R6 status off", v, 32'h0);
        wr(4'd4, 32'd2);
        base = nlog;
        item(32'h6, a, g);
        chk("R6 no ack when off", {31'b0, a}, 32'h0);
        chk("R6 no access when off", nlog - base, 32'd0);
        wr(4'd0, 32'h3);
        rd(4'd1, v); chk("R6 off wins", v, 32'h0);
        wr(4'd0, 32'h1);
        item(32'h7, a, g);
        chk("R6 ack after on", {31'b0, a}, 32'h1);
        wr(4'd4, 32'd0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(4'd7, 32'h2);
        rd(4'd9, v); chk("R7 mask set", v, 32'h2);
        chk("R7 irq finished", {31'b0, irq}, 32'h1);
        wr(4'd8, 32'h2);
        rd(4'd9, v); chk("R7 mask clr", v, 32'h0);
        chk("R7 irq low", {31'b0, irq}, 32'h0);
        wr(4'd7, 32'h4);
        chk("R7 err masked no src", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_error;
        logic [31:0] v, g;
        bit a;
        int base;
        err_addr = 32'h500;
        setup(32'h4FC, 32'd3, 32'h2);
        item(32'h8, a, g);
        chk("R10 first ok", {31'b0, a}, 32'h1);
        item(32'h9, a, g);
        chk("R10 no ack on err", {31'b0, a}, 32'h0);
        rd(4'd10, v); chk("R8 err src", v & 32'h4, 32'h4);
        chk("R7 irq on err", {31'b0, irq}, 32'h1);
        rd(4'd3, v); chk("R10 addr held", v, 32'h500);
        rd(4'd4, v); chk("R10 count held", v, 32'd2);
        err_addr = 32'hFFFF_FFFF;
        base = nlog;
        item(32'hA, a, g);
        chk("R10 frozen", {31'b0, a}, 32'h0);
        chk("R10 frozen access", nlog - base, 32'd0);
        wr(4'd0, 32'h2);
        rd(4'd10, v); chk("R10 sticky off", v & 32'h4, 32'h4);
        wr(4'd0, 32'h1);
        rd(4'd10, v); chk("R10 cleared", v & 32'h4, 32'h0);
        item(32'hB, a, g);
        chk("R10 resumes", {31'b0, a}, 32'h1);
        chk("R10 resume addr", log_addr[base], 32'h500);
        rd(4'd4, v); chk("R3 after resume", v, 32'd1);
        wr(4'd8, 32'h7);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_word_write;
        t_half_read;
        t_byte;
        t_reload;
        t_zero_count;
        t_disable;
        t_mask;
        t_error;
        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run;
        end
    end

endmodule